// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

This block is a purely combinational 32-bit arithmetic and logic unit. It takes two operands and a 4-bit operation select and returns a 32-bit result together with a zero flag and a signed-overflow flag. Any sign or zero extension of short operands is done upstream, so both operands arrive at full width.

All arithmetic goes through a single ripple adder chain. For subtraction, each bit of the second operand is inverted and the chain's carry-in is forced to one. The adder's carries feed three things: the overflow flag, the signed less-than result and the unsigned less-than result. A bitwise unit handles the four logic functions. An output selector picks one of these results according to the operation code. Codes that are not assigned produce an all-zero result.

Top module: `int_alu`

## Requirements
- R1: Codes 0x0 (signed add) and 0x1 (unsigned add) drive the result to A + B modulo 2^32.
- R2: Codes 0x2 (signed subtract) and 0x3 (unsigned subtract) drive the result to A - B modulo 2^32.
- R3: The overflow flag can be 1 only for codes 0x0 and 0x2. For those two codes it is 1 exactly when the signed two's-complement result does not fit in 32 bits. For every other code it is 0, including the unsigned add and subtract codes.
- R4: The logic codes are 0x4 AND, 0x5 OR, 0x6 XOR and 0x7 NOR, each applied bit by bit.
- R5: Code 0xA (signed less-than) returns 1 in bit 0 when A < B as two's-complement numbers and 0 otherwise, with bits 31..1 at 0. The answer stays correct when A - B overflows.
- R6: Code 0xB (unsigned less-than) returns 1 in bit 0 when A < B as unsigned numbers and 0 otherwise, with bits 31..1 at 0.
- R7: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R8: Codes 0x8, 0x9 and 0xC to 0xF produce a result of 0 and an overflow flag of 0, so the zero flag is 1.
- R9: The two compares disagree on mixed signs. With A = 0x00000001 and B = 0xFFFFFFFF, code 0xA gives 0 and code 0xB gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First operand |
| opd_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation select code |
| res | output | 32 | Selected result |
| zero_flag | output | 1 | High when res is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |

## Verification
The zero flag and the overflow flag can both be set in the same evaluation. Adding 0x80000000 to itself wraps to zero and also overflows. Subtracting 0x80000000 from itself gives zero with no overflow. Directed cases force both situations, and the bench checks each flag on its own against the model.

A second pairing is overflow inside a signed compare. For example, 0x80000000 against 0x00000001 makes the subtraction wrap. The bench checks that the compare result still follows the true signed order while the overflow flag stays low for that code.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_ripple_addsub.sv
module alu_ripple_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         sgn_ovf
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign carry[0] = do_sub;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign b_eff[i]   = b[i] ^ do_sub;
    assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (a[i] & carry[i]) | (b_eff[i] & carry[i]);
  end

  assign carry_out = carry[W];
  assign sgn_ovf   = carry[W-1] ^ carry[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    opd_a,
  input  logic [W-1:0]    opd_b,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    res,
  output logic            zero_flag,
  output logic            ovf_flag
);
  logic [W-1:0] as_sum;
  logic         as_cout;
  logic         as_ovf;
  logic         sub_mode;
  logic [W-1:0] lg_y;
  logic_fn_e    lg_fn;
  logic         lt_s;
  logic         lt_u;

  // Only add codes use the chain in add mode; all others subtract.
  assign sub_mode = !(op_sel == OP_ADD || op_sel == OP_ADDU);
  assign lg_fn    = logic_fn_e'(op_sel[1:0]);

  alu_ripple_addsub #(.W(W)) u_addsub (
    .a(opd_a), .b(opd_b), .do_sub(sub_mode),
    .sum(as_sum), .carry_out(as_cout), .sgn_ovf(as_ovf)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a(opd_a), .b(opd_b), .fn(lg_fn), .y(lg_y)
  );

  // Sign of the difference corrected by overflow; borrow means below.
  assign lt_s = as_sum[W-1] ^ as_ovf;
  assign lt_u = ~as_cout;

  always_comb begin
    res      = '0;
    ovf_flag = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        res      = as_sum;
        ovf_flag = as_ovf;
      end
      OP_ADDU, OP_SUBU:                res = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  res = lg_y;
      OP_SLT:                          res = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                         res = {{(W-1){1'b0}}, lt_u};
      default: begin
        res      = '0;
        ovf_flag = 1'b0;
      end
    endcase
  end

  assign zero_flag = ~|res;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0]    opd_a,
  input logic [W-1:0]    opd_b,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    res,
  input logic            zero_flag,
  input logic            ovf_flag
);
  logic [W-1:0] ref_add;
  logic [W-1:0] ref_sub;
  assign ref_add = opd_a + opd_b;
  assign ref_sub = opd_a - opd_b;

  always_comb begin
    // R1
    if (op_sel == OP_ADD || op_sel == OP_ADDU)
      p_add_value_r1: assert (res == ref_add);
    // R2
    if (op_sel == OP_SUB || op_sel == OP_SUBU)
      p_sub_value_r2: assert (res == ref_sub);
    // R3
    if (op_sel != OP_ADD && op_sel != OP_SUB)
      p_no_overflow_r3: assert (!ovf_flag);
    // R5
    if (op_sel == OP_SLT)
      p_slt_upper_r5: assert (res[W-1:1] == '0);
    // R6
    if (op_sel == OP_SLTU)
      p_sltu_value_r6: assert (res == {{(W-1){1'b0}}, (opd_a < opd_b)});
    // R8
    if (op_sel == 4'h8 || op_sel == 4'h9 || op_sel >= 4'hC)
      p_unused_quiet_r8: assert (res == '0 && !ovf_flag && zero_flag);
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_int_alu_chk (
  .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel),
  .res(res), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opd_a, opd_b;
  logic [3:0]   op_sel;
  logic [W-1:0] res;
  logic         zero_flag, ovf_flag;
  int           n_checks, n_fail;
  bit           done;

  int_alu #(.W(W)) u_int_alu (
    .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel),
    .res(res), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] exp_res(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      4'h0, 4'h1: return a + b;
      4'h2, 4'h3: return a - b;
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return a ^ b;
      4'h7: return ~(a | b);
      4'hA: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'hB: return (a < b) ? 32'd1 : 32'd0;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] s;
    if (op == 4'h0) begin
      s = a + b;
      return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    end
    if (op == 4'h2) begin
      s = a - b;
      return (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
    end
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'hA: return "R5";
      4'hB: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", req, op_sel, opd_a, opd_b, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    @(negedge clk);
    op_sel = op; opd_a = a; opd_b = b;
    #(CLK_PERIOD/4);
    er = exp_res(op, a, b);
    chk(req_of(op), res, er);
    chk("R7", {31'd0, zero_flag}, {31'd0, (er == '0)});
    chk("R3", {31'd0, ovf_flag}, {31'd0, exp_ovf(op, a, b)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b0; opd_a = '0; opd_b = '0; op_sel = 4'h0;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    chk("R7", {31'd0, zero_flag}, 32'd1);   // quiet start: 0+0
    chk("R1", res, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R9: mixed-sign compare disagreement
    apply(4'hA, 32'h1, 32'hFFFF_FFFF);
    chk("R9", res, 32'd0);
    apply(4'hB, 32'h1, 32'hFFFF_FFFF);
    chk("R9", res, 32'd1);
    // R3/R7: zero and overflow together
    apply(4'h0, 32'h8000_0000, 32'h8000_0000);
    chk("R3", {31'd0, ovf_flag}, 32'd1);
    apply(4'h1, 32'h8000_0000, 32'h8000_0000);
    apply(4'h0, 32'h7FFF_FFFF, 32'h1);
    apply(4'h1, 32'hFFFF_FFFF, 32'h1);
    apply(4'h2, 32'h8000_0000, 32'h8000_0000);
    apply(4'h2, 32'h8000_0000, 32'h1);
    apply(4'h3, 32'h0, 32'h1);
    apply(4'h2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R5: compare when subtraction overflows
    apply(4'hA, 32'h8000_0000, 32'h1);
    apply(4'hA, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(4'hA, 32'h5, 32'h5);
    apply(4'hB, 32'h5, 32'h5);
    apply(4'hB, 32'h0, 32'hFFFF_FFFF);
    // R4 logic with patterns
    apply(4'h4, 32'hF0F0_1234, 32'hFF00_FF0F);
    apply(4'h5, 32'hF0F0_1234, 32'h0F00_00C0);
    apply(4'h6, 32'hAAAA_5555, 32'hFFFF_0000);
    apply(4'h7, 32'h0, 32'h0);
    apply(4'h7, 32'hFFFF_0000, 32'h0000_FFFF);
    // R8 unused codes with operands that would overflow
    foreach (int_alu_bench.op_list[k]) apply(op_list[k], 32'h8000_0000, 32'h8000_0000);

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 7 == 0) rb = ra;
      if (i % 11 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      apply(4'($urandom % 16), ra, rb);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  logic [3:0] op_list [6] = '{4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};
endmodule